// File: doc/BRIEF.md
# Oversampling Baud Tick Generator

This block takes a fast functional clock and produces the sampling strobe that a UART receiver and transmitter use at sixteen times the bit rate. It also divides that strobe by sixteen to give a strobe once per bit. There are two ways to divide the clock, and a mode input chooses between them.

The integer way is a reloading down-counter, so every strobe is the same number of clocks apart. The fractional way adds the oversampling factor to an accumulator on every clock. Each time the running sum goes above the divisor, the block emits a strobe and subtracts the divisor from the sum. Successive strobes can then be one clock apart in spacing, but every group of sixteen strobes covers exactly the divisor's number of clocks. The bit rate then comes out as the clock frequency divided by the divisor, even when the divisor is small. As an example, a 50 MHz clock with a divisor of 54 gives strobes 3 or 4 clocks apart and a bit of 54 clocks, which is close to 921600 baud.

Software sets the mode and the divisor first and raises the enable after that. While the enable is low, all the dividing state is held at zero.

Top module: `baud_tick_gen`

## Requirements
- R1: `frac_sel` = 1 selects fractional division and `frac_sel` = 0 selects integer division. With the same divisor D, the two modes give different bit periods: D clocks in fractional mode against 16·(D+1) clocks in integer mode.
- R2: In fractional mode, 16 is added to the accumulator on each enabled clock. When the sum exceeds the effective divisor E, one 16x strobe is produced and E is subtracted from the sum. Consecutive strobes are therefore either floor(E/16) or floor(E/16)+1 clocks apart.
- R3: In fractional mode, the interval between consecutive bit strobes is exactly E clocks.
- R4: In fractional mode, E is `divisor` when `divisor` is 16 or more, and E is 16 otherwise. Any divisor below 16 therefore gives a bit period of 16 clocks.
- R5: In integer mode, consecutive 16x strobes are exactly `divisor`+1 clocks apart.
- R6: While `en` is low, the accumulator, the integer counter and the strobe counter are held at zero. From the clock after `en` is sampled low, both outputs stay low.
- R7: `bit_tick` is high only in a cycle where `os_tick` is also high, and it is high on every 16th strobe counted from the rising of `en`.
- R8: While reset is asserted (`rst_n` low, asynchronous), both outputs are low.
- R9: The first strobe after `en` rises appears on the output 1 clock later in integer mode, and floor(E/16)+1 clocks later in fractional mode. This delay includes the output register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Functional clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Runs the dividers when high; clears them when low |
| frac_sel | input | 1 | 1 selects fractional division, 0 selects integer division |
| divisor | input | DIV_W | Division value, to be changed only while `en` is low |
| os_tick | output | 1 | One-clock 16x oversampling strobe |
| bit_tick | output | 1 | One-clock strobe on every 16th `os_tick` |

## Verification
A fractional divisor of 54 gives uneven 3/4-clock spacing, so the bench can check that the bit period stays exact even when the individual gaps differ. A divisor that is a multiple of 16 should give perfectly even spacing. Divisors below 16 separate correct clamping from raw use of the value. Using the same divisor in integer mode separates the two modes by bit length. Randomly chosen windows are each cut off partway through a bit. Because of that, the strobe count in the following window shows whether disabling the block really clears the divide-by-16 counter.

// File: rtl/baud_tick_pkg.sv
package baud_tick_pkg;

  localparam int OVS_DEFAULT = 16;

  typedef enum logic {
    SEL_INTEGER    = 1'b0,
    SEL_FRACTIONAL = 1'b1
  } div_sel_e;

endpackage

// File: rtl/baud_frac_accum.sv
// Modulo accumulator: adds OVS each enabled clock, fires when the sum passes
// the effective divisor and keeps the remainder.
module baud_frac_accum #(
  parameter int DIV_W = 32,
  parameter int OVS   = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] divisor,
  output logic             hit
);
  localparam int ACC_W = DIV_W + 1;
  localparam logic [ACC_W-1:0] STEP = ACC_W'(OVS);

  logic [ACC_W-1:0] acc_q;
  logic [ACC_W-1:0] eff;
  logic [ACC_W-1:0] sum;

  always_comb begin
    eff = {1'b0, divisor};
    if (eff < STEP) eff = STEP;
    sum = acc_q + STEP;
    hit = run && (sum > eff);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      acc_q <= '0;
    else if (!run)   acc_q <= '0;
    else if (hit)    acc_q <= sum - eff;
    else             acc_q <= sum;
  end
endmodule

// File: rtl/baud_int_divider.sv
// Reloading down-counter: fires at zero, so the period is divisor+1 clocks.
module baud_int_divider #(
  parameter int DIV_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] divisor,
  output logic             hit
);
  logic [DIV_W-1:0] cnt_q;

  assign hit = run && (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt_q <= '0;
    else if (!run)  cnt_q <= '0;
    else if (hit)   cnt_q <= divisor;
    else            cnt_q <= cnt_q - 1'b1;
  end
endmodule

// File: rtl/baud_bit_divider.sv
// Counts oversampling strobes and flags the last one of each bit.
module baud_bit_divider #(
  parameter int OVS = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic tick_in,
  output logic hit
);
  generate
    if (OVS == 1) begin : g_pass
      assign hit = tick_in;
    end else begin : g_cnt
      localparam int CW = $clog2(OVS);
      localparam logic [CW-1:0] LAST = CW'(OVS - 1);
      logic [CW-1:0] cnt_q;

      assign hit = tick_in && (cnt_q == LAST);

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        cnt_q <= '0;
        else if (!run)     cnt_q <= '0;
        else if (tick_in)  cnt_q <= hit ? '0 : cnt_q + 1'b1;
      end
    end
  endgenerate
endmodule

// File: rtl/baud_tick_gen.sv
module baud_tick_gen
  import baud_tick_pkg::*;
#(
  parameter int DIV_W = 32,
  parameter int OVS   = OVS_DEFAULT
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             frac_sel,
  input  logic [DIV_W-1:0] divisor,
  output logic             os_tick,
  output logic             bit_tick
);
  div_sel_e mode;
  logic     run_frac, run_int;
  logic     frac_hit, int_hit, raw_tick, bit_hit;
  logic     os_tick_q, bit_tick_q;

  assign mode     = div_sel_e'(frac_sel);
  assign run_frac = en && (mode == SEL_FRACTIONAL);
  assign run_int  = en && (mode == SEL_INTEGER);

  baud_frac_accum #(.DIV_W(DIV_W), .OVS(OVS)) u_frac (
    .clk(clk), .rst_n(rst_n), .run(run_frac), .divisor(divisor), .hit(frac_hit)
  );

  baud_int_divider #(.DIV_W(DIV_W)) u_int (
    .clk(clk), .rst_n(rst_n), .run(run_int), .divisor(divisor), .hit(int_hit)
  );

  assign raw_tick = frac_hit | int_hit;

  baud_bit_divider #(.OVS(OVS)) u_bit (
    .clk(clk), .rst_n(rst_n), .run(en), .tick_in(raw_tick), .hit(bit_hit)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      os_tick_q  <= 1'b0;
      bit_tick_q <= 1'b0;
    end else begin
      os_tick_q  <= raw_tick;
      bit_tick_q <= bit_hit;
    end
  end

  assign os_tick  = os_tick_q;
  assign bit_tick = bit_tick_q;
endmodule

// File: rtl/baud_tick_chk.sv
// Port-level checker. Spacing checks assume divisor and mode change only while en is low.
module baud_tick_chk #(
  parameter int DIV_W = 32,
  parameter int OVS   = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             en,
  input logic             frac_sel,
  input logic [DIV_W-1:0] divisor,
  input logic             os_tick,
  input logic             bit_tick
);
  localparam int GW = DIV_W + 2;

  logic [GW-1:0]    gap_q, bgap_q, eff_w, lim_w;
  logic             seen_q, bseen_q, chg, sel_q;
  logic [DIV_W-1:0] div_q;
  logic [31:0]      tcnt_q;

  assign eff_w = (divisor < DIV_W'(OVS)) ? GW'(OVS) : GW'(divisor);
  assign lim_w = GW'(divisor) + 1'b1;
  assign chg   = (divisor != div_q) || (frac_sel != sel_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_q <= '0; bgap_q <= '0; seen_q <= 1'b0; bseen_q <= 1'b0;
      div_q <= '0; sel_q <= 1'b0; tcnt_q <= '0;
    end else begin
      div_q <= divisor;
      sel_q <= frac_sel;
      if (os_tick) gap_q <= GW'(1);
      else if (gap_q != '1) gap_q <= gap_q + 1'b1;
      if (bit_tick) bgap_q <= GW'(1);
      else if (bgap_q != '1) bgap_q <= bgap_q + 1'b1;
      if (!en || chg) seen_q <= 1'b0;
      else if (os_tick) seen_q <= 1'b1;
      if (!en || chg) bseen_q <= 1'b0;
      else if (bit_tick) bseen_q <= 1'b1;
      if (!en) tcnt_q <= '0;
      else if (os_tick) tcnt_q <= (tcnt_q == 32'(OVS - 1)) ? '0 : tcnt_q + 1;
    end
  end

  // R2: fractional strobe spacing is floor(E/16) or one more
  p_frac_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_q && frac_sel && os_tick) |->
      (gap_q >= eff_w / GW'(OVS)) && (gap_q <= eff_w / GW'(OVS) + 1'b1));

  // R3: fractional bit period equals E
  p_frac_bit_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bseen_q && frac_sel && bit_tick) |-> (bgap_q == eff_w));

  // R5: integer strobe spacing is divisor+1
  p_int_gap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_q && !frac_sel && os_tick) |-> (gap_q == lim_w));

  // R6: quiet after en is sampled low
  p_quiet_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!os_tick && !bit_tick));

  // R7: bit strobe only with a strobe, on every 16th one
  p_bit_align_r7: assert property (@(posedge clk) disable iff (!rst_n)
    bit_tick |-> os_tick);

  p_bit_count_r7: assert property (@(posedge clk) disable iff (!rst_n)
    os_tick |-> (bit_tick == (tcnt_q == 32'(OVS - 1))));
endmodule

bind baud_tick_gen baud_tick_chk #(.DIV_W(DIV_W), .OVS(OVS)) u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .frac_sel(frac_sel),
  .divisor(divisor), .os_tick(os_tick), .bit_tick(bit_tick)
);

// File: tb/test_baud_tick_gen.sv
`timescale 1ns/1ps
module test_baud_tick_gen;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        en;
  logic        frac_sel;
  logic [31:0] divisor;
  logic        os_tick, bit_tick;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk;

  baud_tick_gen i_baud_tick_gen (
    .clk(clk), .rst_n(rst_n), .en(en), .frac_sel(frac_sel),
    .divisor(divisor), .os_tick(os_tick), .bit_tick(bit_tick)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic longint eff_of(input int unsigned dv);
    return (dv < 16) ? 16 : longint'(dv);
  endfunction

  function automatic longint bit_len(input bit fs, input int unsigned dv);
    return fs ? eff_of(dv) : 16 * (longint'(dv) + 1);
  endfunction

  // Disable, configure, enable, then measure for ncyc clocks.
  task automatic run_window(input bit fs, input int unsigned dv, input int ncyc);
    longint eff = eff_of(dv);
    longint last_t = -1, last_b = -1;
    int ntk = 0, since_bit = 0;
    string tag_p = (fs && dv < 16) ? "R4" : (fs ? "R3" : "R1");
    en = 1'b0;
    repeat (3) @(negedge clk);
    chk(!os_tick && !bit_tick, "R6", {os_tick, bit_tick}, 0);
    frac_sel = fs;
    divisor  = dv;
    @(negedge clk);
    en = 1'b1;
    for (int i = 1; i <= ncyc; i++) begin
      @(negedge clk);
      if (os_tick) begin
        ntk++;
        since_bit++;
        if (ntk == 1)
          chk(i == (fs ? eff / 16 + 1 : 1), "R9", i, fs ? eff / 16 + 1 : 1);
        else if (fs)
          chk((i - last_t) >= eff / 16 && (i - last_t) <= eff / 16 + 1, "R2", i - last_t, eff / 16);
        else
          chk((i - last_t) == longint'(dv) + 1, "R5", i - last_t, longint'(dv) + 1);
        last_t = i;
      end
      if (bit_tick) begin
        chk(os_tick == 1'b1, "R7", os_tick, 1);
        chk(since_bit == 16, "R7", since_bit, 16);
        if (last_b >= 0)
          chk((i - last_b) == bit_len(fs, dv), tag_p, i - last_b, bit_len(fs, dv));
        last_b = i;
        since_bit = 0;
      end
    end
  endtask

  initial begin
    int unsigned dv;
    bit fs;
    void'($urandom(32'd20240611));
    rst_n = 1'b0; en = 1'b0; frac_sel = 1'b1; divisor = 32'd54;
    repeat (3) @(negedge clk);
    chk(!os_tick && !bit_tick, "R8", {os_tick, bit_tick}, 0);
    rst_n = 1'b1;
    // R6: configured but not enabled stays silent
    begin
      int seen = 0;
      for (int i = 0; i < 60; i++) begin
        @(negedge clk);
        if (os_tick || bit_tick) seen++;
      end
      chk(seen == 0, "R6", seen, 0);
    end
    run_window(1'b1, 32'd54, 300);    // R2 R3: uneven gaps, exact bit
    run_window(1'b1, 32'd64, 300);    // R2: even spacing
    run_window(1'b1, 32'd5, 120);     // R4: clamp
    run_window(1'b1, 32'd16, 100);    // R4 R9: boundary
    run_window(1'b1, 32'd1000, 3100);
    run_window(1'b0, 32'd54, 2700);   // R1: same divisor, integer mode
    run_window(1'b0, 32'd0, 80);      // R5: every clock
    run_window(1'b0, 32'd3, 230);
    run_window(1'b1, 32'd54, 137);    // cut mid-bit for R6 counter clear
    for (int k = 0; k < 12; k++) begin
      fs = 1'($urandom);
      dv = fs ? $urandom % 300 : $urandom % 40;
      run_window(fs, dv, int'(3 * bit_len(fs, dv)) + 20 + int'($urandom % 40));
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule